// File: doc/BRIEF.md
# Programmable PWM Waveform Generator

This block produces one pulse-width-modulated square wave. An 8-bit counter advances on count ticks. Two equality compares act on it: a period compare that restarts the count, and a duty compare that changes the level of an output latch. In edge-aligned mode the counter climbs and wraps. In center-aligned mode it climbs to the period value and falls back to zero, which gives a symmetric pulse. The count tick comes from a source selector, which picks either every system clock or a strobe input already in the clock domain. A power-of-two prescaler then divides the chosen source.

Software loads the period, duty and wave-shape settings through a small write port into staging copies. The period, duty, polarity and alignment move into the working copies only when the counter restarts, so a period is never cut short or stretched by a write. The source select and the prescale setting take effect at once.

The output rises or falls from two compare events. The restart puts the latch in its leading phase. The duty compare moves it to its trailing phase. In center mode the downward crossing of the duty value puts it back in the leading phase. The trailing phase therefore covers the counts at or above the duty value. In edge-aligned mode the trailing share of a period is (period - duty) / period.

Top module: `pwm_wavegen`

## Requirements
- R1: After reset the count is 0, every setting is 0 and `pwm_out` is 1. With no writes, `pwm_out` stays 1.
- R2: A write with `wr_en` high stores `wr_data` in a staging copy. Address 0 holds the period and address 1 holds the duty value. Address 2 holds the control field: bit 0 is polarity, bit 1 is alignment (1 = center), bit 2 is the source (1 = `ext_tick`), and bits 4:3 set the prescale exponent.
- R3: In edge-aligned mode the count runs 0, 1, ..., P-1 and then restarts at 0, so one period lasts P ticks. A period value of 0 or 1 holds the count at 0 and restarts it on every tick.
- R4: In center-aligned mode with P ≥ 1, the count runs 0, 1, ..., P, P-1, ..., 1 and then restarts at 0, so one period lasts 2P ticks. A period value of 0 holds the count at 0.
- R5: The output is in its trailing phase exactly while count ≥ duty, and in its leading phase otherwise.
- R6: With polarity 0 the leading phase drives 0 and the trailing phase drives 1. Polarity 1 swaps the two levels.
- R7: A duty value of 0 gives a constant trailing level. In edge-aligned mode, a duty value ≥ P gives a constant leading level. In center mode, duty > P gives a constant leading level, and duty = P gives the trailing level only for the one tick at the peak.
- R8: The staged period, duty, polarity and alignment reach the working copies only on a restart tick. A write in mid-period leaves the current period unchanged.
- R9: A count tick happens once every 2^k source pulses, where k is the prescale exponent. The source is every clock cycle, or each cycle in which `ext_tick` is high. A change of source or exponent applies at once.
- R10: In a cycle with no count tick, the count and `pwm_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 duty, 2 control |
| wr_data | input | W (8) | Write data |
| ext_tick | input | 1 | External count strobe, synchronous to clk |
| pwm_out | output | 1 | PWM waveform |

## Verification
The hardest situation to reach from the ports is a write that lands in the middle of a running period. The check must show that this write stays invisible until the next restart, and that it then takes effect on exactly the right tick. The bench starts each run from reset, where a zero period restarts the counter on every tick. This lets it place the first tick of the new shape on a known cycle. It then issues writes at known count values and predicts the waveform arithmetically across the boundary. An exhaustive sweep over small periods, every duty value up to period + 1, both alignments and both polarities covers the boundary levels. Pulse widths measured in clock cycles cover the prescaler and the external source.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;

    localparam int DIV_W  = 2;
    localparam int CTRL_W = 5;

    typedef enum logic [1:0] {
        ADDR_PERIOD = 2'd0,
        ADDR_DUTY   = 2'd1,
        ADDR_CTRL   = 2'd2
    } reg_addr_e;

    typedef enum logic {
        ALIGN_EDGE   = 1'b0,
        ALIGN_CENTER = 1'b1
    } align_e;

    typedef enum logic {
        SRC_SYS = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    // control word, bit 0 is the LSB
    typedef struct packed {
        logic [DIV_W-1:0] div;
        src_e             src;
        align_e           align;
        logic             pol;
    } ctrl_t;

    // part of the control word that waits for a restart
    typedef struct packed {
        align_e align;
        logic   pol;
    } wave_t;

    function automatic logic level_of(input logic lead, input logic pol);
        return lead ? pol : ~pol;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic                 restart,
    output logic [W-1:0]         act_period,
    output logic [W-1:0]         act_duty,
    output logic [W-1:0]         nxt_duty,
    output wave_t                act_wave,
    output src_e                 src_sel,
    output logic [DIV_W-1:0]     div
);
    logic [W-1:0] stg_period;
    logic [W-1:0] stg_duty;
    wave_t        stg_wave;
    ctrl_t        wr_ctrl;
    logic         hi_unused;

    assign wr_ctrl   = ctrl_t'(wr_data[CTRL_W-1:0]);
    assign hi_unused = ^wr_data[W-1:CTRL_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_period <= '0;
            stg_duty   <= '0;
            stg_wave   <= '{align: ALIGN_EDGE, pol: 1'b0};
            src_sel    <= SRC_SYS;
            div        <= '0;
        end else if (wr_en) begin
            unique case (wr_addr)
                ADDR_PERIOD: stg_period <= wr_data;
                ADDR_DUTY:   stg_duty   <= wr_data;
                ADDR_CTRL: begin
                    stg_wave <= '{align: wr_ctrl.align, pol: wr_ctrl.pol};
                    src_sel  <= wr_ctrl.src;
                    div      <= wr_ctrl.div;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_period <= '0;
            act_duty   <= '0;
            act_wave   <= '{align: ALIGN_EDGE, pol: 1'b0};
        end else if (restart) begin
            act_period <= stg_period;
            act_duty   <= stg_duty;
            act_wave   <= stg_wave;
        end
    end

    assign nxt_duty = restart ? stg_duty : act_duty;

endmodule

// File: rtl/pwm_prescale.sv
`timescale 1ns/1ps
module pwm_prescale
    import pwm_pkg::*;
#(
    parameter int DW = DIV_W
) (
    input  logic          clk,
    input  logic          rst,
    input  src_e          src_sel,
    input  logic          ext_tick,
    input  logic [DW-1:0] div,
    output logic          tick
);
    localparam int PRE_W = (1 << DW) - 1;

    logic [PRE_W-1:0] pre;
    logic [PRE_W-1:0] lim;
    logic             src_on;

    assign lim    = ~({PRE_W{1'b1}} << div);
    assign src_on = (src_sel == SRC_EXT) ? ext_tick : 1'b1;
    assign tick   = src_on && (pre >= lim);

    always_ff @(posedge clk) begin
        if (rst)         pre <= '0;
        else if (tick)   pre <= '0;
        else if (src_on) pre <= pre + 1'b1;
    end

endmodule

// File: rtl/pwm_counter.sv
`timescale 1ns/1ps
module pwm_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         center,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_next,
    output logic         down_step,
    output logic         restart
);
    logic down, down_n, wrap;

    always_comb begin
        cnt_next  = cnt;
        down_n    = down;
        wrap      = 1'b0;
        down_step = 1'b0;
        if (!center) begin
            down_n = 1'b0;
            if (period <= 1 || cnt >= period - 1'b1) begin
                cnt_next = '0;
                wrap     = 1'b1;
            end else begin
                cnt_next = cnt + 1'b1;
            end
        end else if (!down) begin
            if (cnt >= period) begin
                if (period == '0) begin
                    cnt_next = '0;
                    wrap     = 1'b1;
                end else begin
                    cnt_next  = cnt - 1'b1;
                    down_step = 1'b1;
                    wrap      = (cnt_next == '0);
                    down_n    = !wrap;
                end
            end else begin
                cnt_next = cnt + 1'b1;
            end
        end else begin
            cnt_next  = cnt - 1'b1;
            down_step = 1'b1;
            wrap      = (cnt_next == '0);
            down_n    = !wrap;
        end
    end

    assign restart = tick && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            down <= 1'b0;
        end else if (tick) begin
            cnt  <= cnt_next;
            down <= down_n;
        end
    end

endmodule

// File: rtl/pwm_outlatch.sv
`timescale 1ns/1ps
module pwm_outlatch
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         restart,
    input  logic         down_step,
    input  logic [W-1:0] cnt_next,
    input  logic [W-1:0] duty,
    input  logic         pol,
    output logic         pwm_out
);
    logic lead, set_ev, clr_ev;

    // set: restart, or a downward step that lands one below duty
    assign set_ev = restart || (down_step && ({1'b0, cnt_next} + 1'b1 == {1'b0, duty}));
    // clear: count lands on duty (clear wins)
    assign clr_ev = (cnt_next == duty);

    always_ff @(posedge clk) begin
        if (rst)               lead <= 1'b0;
        else if (tick) begin
            if (clr_ev)        lead <= 1'b0;
            else if (set_ev)   lead <= 1'b1;
        end
    end

    assign pwm_out = level_of(lead, pol);

endmodule

// File: rtl/pwm_wavegen.sv
`timescale 1ns/1ps
module pwm_wavegen
    import pwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         ext_tick,
    output logic         pwm_out
);
    logic [W-1:0]     act_period, act_duty, nxt_duty, cnt, cnt_next;
    wave_t            act_wave;
    src_e             src_sel;
    logic [DIV_W-1:0] div;
    logic             cnt_tick, restart, down_step, act_center, act_pol;

    assign act_center = (act_wave.align == ALIGN_CENTER);
    assign act_pol    = act_wave.pol;

    pwm_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .restart(restart), .act_period(act_period),
        .act_duty(act_duty), .nxt_duty(nxt_duty), .act_wave(act_wave),
        .src_sel(src_sel), .div(div)
    );

    pwm_prescale #(.DW(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .src_sel(src_sel), .ext_tick(ext_tick),
        .div(div), .tick(cnt_tick)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk(clk), .rst(rst), .tick(cnt_tick), .center(act_center),
        .period(act_period), .cnt(cnt), .cnt_next(cnt_next),
        .down_step(down_step), .restart(restart)
    );

    pwm_outlatch #(.W(W)) u_out (
        .clk(clk), .rst(rst), .tick(cnt_tick), .restart(restart),
        .down_step(down_step), .cnt_next(cnt_next), .duty(nxt_duty),
        .pol(act_pol), .pwm_out(pwm_out)
    );

endmodule

// File: rtl/pwm_wavegen_chk.sv
`timescale 1ns/1ps
module pwm_wavegen_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_tick,
    input logic         restart,
    input logic         ext_tick,
    input logic         src_ext,
    input logic [W-1:0] cnt,
    input logic [W-1:0] act_period,
    input logic [W-1:0] act_duty,
    input logic         act_center,
    input logic         act_pol,
    input logic         pwm_out
);
    // R3 R4
    count_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) || (cnt <= act_period));

    // R3
    edge_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_tick && !act_center) |=> (cnt == '0) || (cnt == $past(cnt) + 1'b1));

    // R4
    center_step_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_tick |=> (cnt == '0) || (cnt == $past(cnt) + 1'b1) || (cnt == $past(cnt) - 1'b1));

    // R5 R6
    level_chk: assert property (@(posedge clk) disable iff (rst)
        pwm_out == ((cnt >= act_duty) ? !act_pol : act_pol));

    // R8
    stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !restart |=> $stable(act_period) && $stable(act_duty));

    // R9
    tick_source_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_tick |-> (!src_ext || ext_tick));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cnt_tick |=> $stable(cnt) && $stable(pwm_out));

endmodule

bind pwm_wavegen pwm_wavegen_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .restart(restart),
    .ext_tick(ext_tick), .src_ext(src_sel == pwm_pkg::SRC_EXT), .cnt(cnt),
    .act_period(act_period), .act_duty(act_duty), .act_center(act_center),
    .act_pol(act_pol), .pwm_out(pwm_out)
);

// File: tb/pwm_wavegen_bench.sv
`timescale 1ns/1ps
module pwm_wavegen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       ext_tick = 1'b0;
    logic       pwm_out;
    logic       ext_run = 1'b0;
    int         ph = 0;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    pwm_wavegen u_pwm_wavegen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ext_tick(ext_tick), .pwm_out(pwm_out)
    );

    // strobe on ext_tick once every 3 clocks while enabled
    always @(negedge clk) begin
        if (ext_run) begin
            ph       <= (ph == 2) ? 0 : ph + 1;
            ext_tick <= (ph == 2);
        end else begin
            ph       <= 0;
            ext_tick <= 1'b0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        ext_run = 1'b0;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // expected output level k ticks after the first restart of a shape
    function automatic int expv(int p, int d, int c, int pl, int k);
        int cv, pos;
        if (c == 0) cv = (p <= 1) ? 0 : k % p;
        else if (p == 0) cv = 0;
        else begin
            pos = k % (2 * p);
            cv  = (pos <= p) ? pos : 2 * p - pos;
        end
        return (cv >= d) ? 1 - pl : pl;
    endfunction

    task automatic setup(int p, int d, int c, int pl, int dv, int sx);
        do_reset();
        wr(2'd2, 8'((dv << 3) | (sx << 2) | (c << 1) | pl));
        wr(2'd1, 8'(d));
        wr(2'd0, 8'(p));
        @(posedge clk);
        @(negedge clk);
    endtask

    // clocks between rising edges and high width, skipping the first rise
    task automatic measure(output int per, output int hi);
        logic prev;
        int   rises, t, t_rise;
        rises = 0; t = 0; t_rise = 0; hi = 0; per = 0;
        prev = pwm_out;
        while (rises < 3) begin
            @(negedge clk);
            t++;
            if (!prev && pwm_out) begin
                rises++;
                if (rises == 3) per = t - t_rise;
                t_rise = t;
            end
            if (prev && !pwm_out && rises == 2) hi = t - t_rise;
            prev = pwm_out;
        end
    endtask

    initial begin
        int per, hi;
        logic held;
        // R1 reset state and idle
        do_reset();
        chk("R1 out after reset", pwm_out, 1);
        repeat (20) @(negedge clk);
        chk("R1 out idle", pwm_out, 1);

        // R2 R3 R4 R5 R6 R7 exhaustive sweep of small shapes
        for (int p = 0; p <= 6; p++)
            for (int d = 0; d <= p + 1; d++)
                for (int c = 0; c < 2; c++)
                    for (int pl = 0; pl < 2; pl++) begin
                        int len;
                        setup(p, d, c, pl, 0, 0);
                        len = (c == 0) ? ((p <= 1) ? 1 : p) : ((p == 0) ? 1 : 2 * p);
                        for (int k = 0; k <= 2 * len + 1; k++) begin
                            string tag;
                            if (k == 0) tag = "R2";
                            else if (d == 0 || d >= p) tag = "R7";
                            else if (pl == 1) tag = "R6";
                            else if (c == 1) tag = "R4";
                            else tag = (k < len) ? "R3" : "R5";
                            chk($sformatf("%s p=%0d d=%0d c=%0d pol=%0d k=%0d", tag, p, d, c, pl, k),
                                pwm_out, expv(p, d, c, pl, k));
                            @(posedge clk);
                            @(negedge clk);
                        end
                    end

        // R8 mid-period writes wait for the restart
        setup(4, 2, 0, 0, 0, 0);
        chk("R8 k=0", pwm_out, expv(4, 2, 0, 0, 0));
        wr(2'd1, 8'd1);
        chk("R8 k=1 old duty", pwm_out, expv(4, 2, 0, 0, 1));
        wr(2'd0, 8'd6);
        chk("R8 k=2 old period", pwm_out, expv(4, 2, 0, 0, 2));
        wr(2'd2, 8'd1);
        chk("R8 k=3 old polarity", pwm_out, expv(4, 2, 0, 0, 3));
        for (int k = 0; k < 14; k++) begin
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R8 new shape k=%0d", k), pwm_out, expv(6, 1, 0, 1, k));
        end

        // R9 prescale exponent 0..3 from the system clock
        for (int dv = 0; dv < 4; dv++) begin
            setup(3, 1, 0, 0, dv, 0);
            measure(per, hi);
            chk($sformatf("R9 period div=%0d", dv), per, 3 << dv);
            chk($sformatf("R9 high div=%0d", dv), hi, 2 << dv);
        end

        // R9 external strobe every 3 clocks, exponent 1
        setup(3, 1, 0, 0, 1, 1);
        ext_run = 1'b1;
        measure(per, hi);
        chk("R9 ext period", per, 18);
        chk("R9 ext high", hi, 12);

        // R10 strobes stop: output frozen
        measure(per, hi);
        repeat (4) @(negedge clk);
        ext_run = 1'b0;
        repeat (3) @(negedge clk);
        held = pwm_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            chk("R10 hold without ticks", pwm_out, held);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule